// File: doc/BRIEF.md
# Symmetric Systolic Streaming FIR Filter

This block is a fully parallel finite impulse response filter for a stream of signed fixed-point samples, one sample per clock, each qualified by a valid strobe. The coefficient set is a fixed parameter and is mirror-symmetric. Each pair of taps that shares a coefficient is summed before the multiply, so an odd filter of N taps needs only (N+1)/2 multipliers. With the default 25 taps, that is 13 multipliers.

The products feed a systolic accumulation chain. Each stage adds its product, skewed in time, to the partial sum handed on by the stage before it. The result carries full precision: it is neither rounded nor saturated. A filtered sample leaves the block with its own valid strobe after a fixed latency.

Cycles in which the input valid is low leave the sample history untouched. The filter therefore sees only qualified samples, and the spacing between them does not matter.

Top module: `fir_sym_systolic`

## Requirements
- R1: A clock edge with `rst_n` low clears the history, the pipeline and the valid tracking. After that edge, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` rises exactly 15 clock edges after the edge that captured a sample with `in_valid` high. The latency is (pairs + centre) + 2. An output pulse never appears without a matching input pulse.
- R3: With h0..h12 = -120, -310, -240, 260, 880, 900, -350, -2100, -2600, 900, 7800, 14500, 17300, the output is y = sum over k=0..11 of hk*(x[k]+x[24-k]) + h12*x[12]. Here x[0] is the newest qualified sample and x[24] is the oldest.
- R4: A sample presented with `in_valid` low is ignored. It does not enter the history, and it does not shift the history.
- R5: `out_data` is 37 bits wide (input 16 + pre-add 1 + coefficient 16 + accumulation 4). It is exact for any 16-bit input, including long runs of -32768 and alternating full-scale values.
- R6: `out_data` is 0 in every cycle in which `out_valid` is 0.
- R7: The centre tap x[12] is weighted once by h12 and is not paired. A unit impulse therefore yields h0..h11, then h12 once, then h11..h0.
- R8: After reset, history positions not yet filled by qualified samples count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a qualified sample |
| in_data | input | 16 | Signed input sample (Q1.15 by default) |
| out_valid | output | 1 | Marks `out_data` as a filtered result |
| out_data | output | 37 | Signed full-precision filter output |

## Verification
The bound checker checks several properties on every cycle:
- reset clears the outputs;
- a qualified sample lands at the head of the history;
- the head holds still when `in_valid` is low;
- output pulses never outnumber the input pulses still in flight.

The exact 15-cycle latency, the convolution values and the full-precision extremes can only be shown by the bench's scenarios. The same holds for the single weighting of the centre tap and for zero history after reset. The bench compares each output against a behavioural convolution kept in the bench, using gapped, impulse, full-scale and mid-stream reset patterns.

// File: rtl/fir_sym_pkg.sv
// Package: shared defaults for the symmetric systolic FIR.
// Holds the default tap count and the first half of the symmetric
// coefficient set (index 0 = outermost pair, last = centre tap).
package fir_sym_pkg;
    localparam int DEF_TAPS   = 25;
    localparam int DEF_HALF   = (DEF_TAPS + 1) / 2;
    localparam int DEF_COEF_W = 16;

    typedef logic signed [DEF_COEF_W-1:0] coef_t;

    localparam coef_t DEF_COEF [DEF_HALF] = '{
        -16'sd120,  -16'sd310,  -16'sd240,   16'sd260,
         16'sd880,   16'sd900,  -16'sd350,  -16'sd2100,
        -16'sd2600,  16'sd900,   16'sd7800,  16'sd14500,
         16'sd17300
    };
endpackage

// File: rtl/fir_tapline.sv
// Module: fir_tapline
// Sample history of NTAPS entries, newest at index 0.
// Assumes: shifts only on qualified samples; synchronous active-low reset.
module fir_tapline #(
    parameter int NTAPS  = 25,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [DATA_W-1:0]              in_data,
    output logic [NTAPS-1:0][DATA_W-1:0]   taps
);
    // Shift the history by one place for each qualified sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (in_valid) begin
            taps[0] <= in_data;
            for (int i = 1; i < NTAPS; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end
endmodule

// File: rtl/fir_preadd_mult.sv
// Module: fir_preadd_mult
// One lane per distinct coefficient: a registered pre-add of the mirrored
// tap pair (or a plain sign extension for the odd centre tap), then a
// registered multiply. Two register stages per lane, free-running.
// Assumes: coefficient array COEF holds the first HALF symmetric values.
module fir_preadd_mult #(
    parameter int NTAPS  = 25,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int HALF   = (NTAPS + 1) / 2,
    parameter int PROD_W = DATA_W + 1 + COEF_W,
    parameter logic signed [COEF_W-1:0] COEF [HALF] = fir_sym_pkg::DEF_COEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NTAPS-1:0][DATA_W-1:0]   taps,
    output logic [HALF-1:0][PROD_W-1:0]    prod
);
    localparam int NPAIR = NTAPS / 2;
    localparam int PRE_W = DATA_W + 1;

    for (genvar k = 0; k < HALF; k++) begin : g_lane
        logic signed [PRE_W-1:0]  pre_q;
        logic signed [PROD_W-1:0] prod_q;

        if (k < NPAIR) begin : g_pair
            // Pre-add the mirrored pair, then weight the sum.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q  <= '0;
                    prod_q <= '0;
                end else begin
                    pre_q  <= PRE_W'($signed(taps[k])) + PRE_W'($signed(taps[NTAPS-1-k]));
                    prod_q <= PROD_W'(pre_q) * PROD_W'(COEF[k]);
                end
            end
        end else begin : g_centre
            // Centre tap of an odd filter: single sample, no partner.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q  <= '0;
                    prod_q <= '0;
                end else begin
                    pre_q  <= PRE_W'($signed(taps[NPAIR]));
                    prod_q <= PROD_W'(pre_q) * PROD_W'(COEF[k]);
                end
            end
        end

        assign prod[k] = prod_q;
    end
endmodule

// File: rtl/fir_sys_acc.sv
// Module: fir_sys_acc
// Systolic accumulation: stage k adds its product, delayed k cycles, to
// the partial sum from stage k-1, so all products of one window meet.
// Latency from a product to acc_out is HALF cycles.
module fir_sys_acc #(
    parameter int HALF   = 13,
    parameter int PROD_W = 33,
    parameter int ACC_W  = PROD_W + $clog2(HALF)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [HALF-1:0][PROD_W-1:0]  prod,
    output logic [ACC_W-1:0]             acc_out
);
    for (genvar k = 0; k < HALF; k++) begin : g_st
        logic signed [ACC_W-1:0] acc_q;

        if (k == 0) begin : g_head
            // First stage: start the partial sum from lane 0.
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= ACC_W'($signed(prod[0]));
            end
        end else begin : g_link
            logic signed [PROD_W-1:0] dl [k];
            // Skew lane k by k cycles, then add it to the incoming sum.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < k; j++) dl[j] <= '0;
                    acc_q <= '0;
                end else begin
                    dl[0] <= $signed(prod[k]);
                    for (int j = 1; j < k; j++) dl[j] <= dl[j-1];
                    acc_q <= g_st[k-1].acc_q + ACC_W'(dl[k-1]);
                end
            end
        end
    end

    assign acc_out = g_st[HALF-1].acc_q;
endmodule

// File: rtl/fir_sym_systolic.sv
// Module: fir_sym_systolic (top)
// Streaming symmetric FIR: gated history, pre-add/multiply lanes,
// systolic accumulation and a valid delay line matched to the datapath.
// Assumes: fixed coefficients, one sample per clock at most, synchronous
// active-low reset. Output is full precision and forced to 0 when idle.
module fir_sym_systolic #(
    parameter int NTAPS  = fir_sym_pkg::DEF_TAPS,
    parameter int DATA_W = 16,
    parameter int COEF_W = fir_sym_pkg::DEF_COEF_W,
    parameter int HALF   = (NTAPS + 1) / 2,
    parameter logic signed [COEF_W-1:0] COEF [HALF] = fir_sym_pkg::DEF_COEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic signed [DATA_W-1:0]          in_data,
    output logic                              out_valid,
    output logic signed [DATA_W+COEF_W+$clog2(HALF):0] out_data
);
    localparam int PROD_W = DATA_W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(HALF);
    localparam int LAT    = HALF + 2;

    logic [NTAPS-1:0][DATA_W-1:0] taps;
    logic [HALF-1:0][PROD_W-1:0]  prod;
    logic [ACC_W-1:0]             acc_out;
    logic [LAT:0]                 vld_q;
    logic [DATA_W-1:0]            tap_head;

    fir_tapline #(.NTAPS(NTAPS), .DATA_W(DATA_W)) u_taps (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_data(in_data), .taps(taps)
    );

    fir_preadd_mult #(
        .NTAPS(NTAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
        .HALF(HALF), .PROD_W(PROD_W), .COEF(COEF)
    ) u_lanes (
        .clk(clk), .rst_n(rst_n), .taps(taps), .prod(prod)
    );

    fir_sys_acc #(.HALF(HALF), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .prod(prod), .acc_out(acc_out)
    );

    // Carry each input valid through the same number of stages as its data.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAT-1:0], in_valid};
    end

    assign tap_head  = taps[0];
    assign out_valid = vld_q[LAT];
    assign out_data  = out_valid ? $signed(acc_out) : '0;
endmodule

// File: rtl/fir_sym_systolic_chk.sv
// Module: fir_sym_systolic_chk
// Cycle-by-cycle properties of the filter, attached by bind below.
module fir_sym_systolic_chk #(
    parameter int LAT    = 15,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 37
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_data,
    input logic [DATA_W-1:0] tap_head
);
    int inflight;

    // Count qualified samples that have not yet produced an output.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= 0;
        else        inflight <= inflight + int'(in_valid) - int'(out_valid);
    end

    // R1: a reset edge leaves both outputs cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R4: a qualified sample becomes the newest history entry
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> tap_head == $past(in_data));

    // R4: unqualified cycles leave the history head untouched
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(tap_head));

    // R2: no output pulse without a pending input pulse
    p_no_orphan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight > 0);

    // R2: pending samples never exceed the pipeline depth
    p_bounded_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= LAT + 1);
endmodule

bind fir_sym_systolic fir_sym_systolic_chk #(
    .LAT(LAT), .DATA_W(DATA_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .tap_head(tap_head)
);

// File: tb/fir_sym_systolic_tb.sv
// Bench: table-driven stream plus directed reset, impulse and extreme
// tests, checked every cycle against a behavioural convolution.
module fir_sym_systolic_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT   = 25;
    localparam int LATC = 16;  // drive negedge to observing negedge
    localparam int NSL  = 2048;

    localparam longint H [13] = '{-120, -310, -240, 260, 880, 900, -350,
                                  -2100, -2600, 900, 7800, 14500, 17300};

    // {valid, data} stream with gaps
    localparam logic [16:0] STIM [32] = '{
        17'h1_1234, 17'h1_8000, 17'h0_7FFF, 17'h1_0F0F, 17'h1_F001, 17'h0_5555,
        17'h0_AAAA, 17'h1_7FFF, 17'h1_0001, 17'h1_FFFF, 17'h0_1111, 17'h1_3C3C,
        17'h1_C3C3, 17'h1_0100, 17'h0_0000, 17'h1_FF00, 17'h1_4000, 17'h1_BFFF,
        17'h0_2222, 17'h0_3333, 17'h1_0042, 17'h1_8001, 17'h1_7000, 17'h1_9000,
        17'h0_6666, 17'h1_0007, 17'h1_FFF9, 17'h1_2468, 17'h1_ACE0, 17'h0_1357,
        17'h1_7531, 17'h1_0ABC
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic signed [36:0] out_data;

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    string  cur_tag = "R3";
    longint hist [NT];
    bit     exp_v [NSL];
    longint exp_d [NSL];

    fir_sym_systolic u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint model_y();
        longint s = 0;
        for (int k = 0; k < 12; k++) s += H[k] * (hist[k] + hist[NT-1-k]);
        s += H[12] * hist[12];
        return s;
    endfunction

    task automatic check_slot(input int slot);
        longint got = longint'(out_data);
        checks++;
        if (out_valid !== exp_v[slot]) begin
            errors++;
            $display("FAIL R2 cycle %0d out_valid got %0b exp %0b", slot, out_valid, exp_v[slot]);
        end
        checks++;
        if (exp_v[slot]) begin
            if (got !== exp_d[slot]) begin
                errors++;
                $display("FAIL %s cycle %0d out_data got %0d exp %0d", cur_tag, slot, got, exp_d[slot]);
            end
        end else if (got !== 0) begin
            errors++;
            $display("FAIL R6 cycle %0d idle out_data got %0d exp 0", slot, got);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d, input logic rst);
        @(negedge clk);
        check_slot(cyc);
        in_valid = v;
        in_data  = d;
        rst_n    = !rst;
        if (rst) begin
            for (int i = 0; i < NT; i++) hist[i] = 0;
            for (int j = 1; j <= LATC; j++) exp_v[cyc+j] = 1'b0;
        end else if (v) begin
            for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = longint'($signed(d));
            exp_v[cyc+LATC] = 1'b1;
            exp_d[cyc+LATC] = model_y();
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) hist[i] = 0;
        for (int i = 0; i < NSL; i++) begin exp_v[i] = 1'b0; exp_d[i] = 0; end

        // R1: held in reset, outputs cleared
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 1'b1);

        // R3 / R4 / R8: table walk with gaps from zeroed history
        cur_tag = "R3";
        for (int i = 0; i < 32; i++) step(STIM[i][16], STIM[i][15:0], 1'b0);
        idle(20);

        // R1: reset while samples are in flight, then R8 fresh history
        cur_tag = "R8";
        for (int i = 0; i < 5; i++) step(1'b1, 16'h7ABC, 1'b0);
        step(1'b1, 16'h1111, 1'b1);
        step(1'b0, 16'h0000, 1'b1);
        step(1'b1, 16'h0100, 1'b0);
        step(1'b1, 16'hFF00, 1'b0);
        idle(20);

        // R7: unit impulse gives the mirrored coefficients, centre once
        cur_tag = "R7";
        step(1'b0, 16'h0000, 1'b1);
        step(1'b1, 16'h0001, 1'b0);
        for (int i = 0; i < 26; i++) step(1'b1, 16'h0000, 1'b0);
        idle(20);

        // R4: gaps with junk data between qualified samples
        cur_tag = "R4";
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 16'(i * 977), 1'b0);
            step(1'b0, 16'hDEAD, 1'b0);
            step(1'b0, 16'h7FFF, 1'b0);
        end
        idle(20);

        // R5: full-scale negative run, then alternating extremes
        cur_tag = "R5";
        for (int i = 0; i < 30; i++) step(1'b1, 16'h8000, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 16'h7FFF : 16'h8000, 1'b0);
        idle(20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d exp completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule